// File: doc/BRIEF.md
# Accumulator Datapath ALU with Carry/Zero Flag Logic

This block is the combinational arithmetic and logic unit of a small 8-bit accumulator machine. It takes the working register, an operand read from the register file, an immediate literal, a bit index and an operation code. It returns the 8-bit result, the next carry and zero values, one write enable for each flag, and a skip indication. The surrounding core uses the skip indication to drop the next instruction.

Each operation updates only its own set of flags. Subtraction computes file operand minus working register and reports carry as "no borrow". The two rotates move bits through the carry flag. The conditional-skip variants of increment and decrement, and the two bit tests, change no flag at all. Instruction decode, writeback steering and the skip sequencing stay in the core around the block. The data width is a parameter, and a second parameter picks how the subtractor is built.

Top module: `alu8_core`

## Requirements
- R1: OP_ADD (code 0) gives result = f + w modulo 2^WIDTH. carry_out is the carry out of the top bit. carry_we and zero_we are both 1.
- R2: OP_SUB (code 1) gives result = f − w. carry_out is 1 when f >= w (no borrow) and 0 otherwise. carry_we and zero_we are both 1.
- R3: OP_INC (2) and OP_DEC (3) return f + 1 and f − 1 with wraparound, so 0xFF goes to 0x00 and 0x00 goes to 0xFF. Only zero_we is 1.
- R4: OP_INCSZ (4) and OP_DECSZ (5) return the same values as R3 and set skip when the result is zero. Both flag enables are 0.
- R5: OP_AND/OP_IOR/OP_XOR (6/7/8) combine w with f. OP_ANDLW/OP_IORLW/OP_XORLW (21/22/23) combine w with lit. For all six, zero_we is 1 and carry_we is 0.
- R6: OP_COM (9) inverts f, OP_MOVF (10) passes f and OP_CLR (12) gives 0; each of these has zero_we = 1. OP_SWAP (13) exchanges the two halves of f and has no flag enable.
- R7: OP_RRF (14) gives {carry_in, f[W-1:1]} with carry_out = f[0]. OP_RLF (15) gives {f[W-2:0], carry_in} with carry_out = f[W-1]. For both, only carry_we is 1.
- R8: OP_BCF (16) and OP_BSF (17) clear or set bit bit_sel of f and leave the other bits alone. Neither has a flag enable.
- R9: OP_BTFSC (18) sets skip when f[bit_sel] is 0, and OP_BTFSS (19) sets skip when it is 1. The result is f, and neither has a flag enable.
- R10: zero_out is 1 exactly when result is all zeros.
- R11: OP_MOVW (11) passes w and OP_MOVLW (20) passes lit. Neither has a flag enable.
- R12: An op code outside 0..23 gives result 0, both flag enables 0 and skip 0.
- R13: skip is 0 for every operation other than the four named in R4 and R9, even when the result is zero.
- R14: When carry_we is 0, carry_out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_in | input | WIDTH | Working register value |
| f_in | input | WIDTH | Register-file operand |
| lit_in | input | WIDTH | Immediate literal |
| bit_sel | input | $clog2(WIDTH) | Bit index for set, clear and test |
| op | input | 5 | Operation code (see package) |
| carry_in | input | 1 | Current carry flag |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Next carry value |
| zero_out | output | 1 | Next zero value |
| carry_we | output | 1 | Carry flag update enable |
| zero_we | output | 1 | Zero flag update enable |
| skip | output | 1 | Skip-next-instruction request |

## Verification
The checker evaluates its properties whenever any input changes. It assumes that the op code, the operands and carry_in change together as one stable input set, and that bit_sel is always a valid index; with WIDTH a power of two, every value of the field is valid. The bench applies each complete input set one clock period apart and reads the outputs half a period later. The checker therefore never sees a partly updated vector, and every op code lands either on a defined operation or on the unused range covered by R12.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_SUB   = 5'd1,
      OP_INC   = 5'd2,
      OP_DEC   = 5'd3,
      OP_INCSZ = 5'd4,
      OP_DECSZ = 5'd5,
      OP_AND   = 5'd6,
      OP_IOR   = 5'd7,
      OP_XOR   = 5'd8,
      OP_COM   = 5'd9,
      OP_MOVF  = 5'd10,
      OP_MOVW  = 5'd11,
      OP_CLR   = 5'd12,
      OP_SWAP  = 5'd13,
      OP_RRF   = 5'd14,
      OP_RLF   = 5'd15,
      OP_BCF   = 5'd16,
      OP_BSF   = 5'd17,
      OP_BTFSC = 5'd18,
      OP_BTFSS = 5'd19,
      OP_MOVLW = 5'd20,
      OP_ANDLW = 5'd21,
      OP_IORLW = 5'd22,
      OP_XORLW = 5'd23
   } alu_op_e;

   typedef enum logic [1:0] {
      GRP_NONE  = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_LOGIC = 2'd2,
      GRP_BITROT = 2'd3
   } alu_grp_e;

   function automatic alu_grp_e op_group(alu_op_e o);
      case (o)
         OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_INCSZ, OP_DECSZ:
            op_group = GRP_ARITH;
         OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOVF, OP_MOVW, OP_CLR,
         OP_SWAP, OP_MOVLW, OP_ANDLW, OP_IORLW, OP_XORLW:
            op_group = GRP_LOGIC;
         OP_RRF, OP_RLF, OP_BCF, OP_BSF, OP_BTFSC, OP_BTFSS:
            op_group = GRP_BITROT;
         default:
            op_group = GRP_NONE;
      endcase
   endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int WIDTH         = 8,
   parameter bit SUB_VIA_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_w,
   input  logic [WIDTH-1:0] a_f,
   input  alu_op_e          a_op,
   output logic [WIDTH-1:0] a_res,
   output logic             a_cout
);
   localparam logic [WIDTH-1:0] ONE   = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH:0]   ONE_X = {{WIDTH{1'b0}}, 1'b1};

   logic [WIDTH:0]   sum_x;
   logic [WIDTH-1:0] diff;
   logic             no_borrow;

   assign sum_x = {1'b0, a_f} + {1'b0, a_w};

   generate
      if (SUB_VIA_ADDER) begin : g_sub_add
         logic [WIDTH:0] dsum;
         assign dsum      = {1'b0, a_f} + {1'b0, ~a_w} + ONE_X;
         assign diff      = dsum[WIDTH-1:0];
         assign no_borrow = dsum[WIDTH];
      end else begin : g_sub_direct
         logic [WIDTH:0] dx;
         assign dx        = {1'b0, a_f} - {1'b0, a_w};
         assign diff      = dx[WIDTH-1:0];
         assign no_borrow = ~dx[WIDTH];
      end
   endgenerate

   always_comb begin
      a_res  = '0;
      a_cout = 1'b0;
      case (a_op)
         OP_ADD: begin
            a_res  = sum_x[WIDTH-1:0];
            a_cout = sum_x[WIDTH];
         end
         OP_SUB: begin
            a_res  = diff;
            a_cout = no_borrow;
         end
         OP_INC, OP_INCSZ: a_res = a_f + ONE;
         OP_DEC, OP_DECSZ: a_res = a_f - ONE;
         default: ;
      endcase
   end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] l_w,
   input  logic [WIDTH-1:0] l_f,
   input  logic [WIDTH-1:0] l_lit,
   input  alu_op_e          l_op,
   output logic [WIDTH-1:0] l_res
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] swapped;
   assign swapped = {l_f[HALF-1:0], l_f[WIDTH-1:HALF]};

   always_comb begin
      case (l_op)
         OP_AND:   l_res = l_w & l_f;
         OP_IOR:   l_res = l_w | l_f;
         OP_XOR:   l_res = l_w ^ l_f;
         OP_ANDLW: l_res = l_w & l_lit;
         OP_IORLW: l_res = l_w | l_lit;
         OP_XORLW: l_res = l_w ^ l_lit;
         OP_COM:   l_res = ~l_f;
         OP_MOVF:  l_res = l_f;
         OP_MOVW:  l_res = l_w;
         OP_MOVLW: l_res = l_lit;
         OP_SWAP:  l_res = swapped;
         default:  l_res = '0;
      endcase
   end
endmodule

// File: rtl/alu8_bitrot.sv
module alu8_bitrot
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] b_f,
   input  logic             b_cin,
   input  logic [BIT_W-1:0] b_sel,
   input  alu_op_e          b_op,
   output logic [WIDTH-1:0] b_res,
   output logic             b_cout,
   output logic             b_tbit
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] mask;
   assign mask   = ONE << b_sel;
   assign b_tbit = |(b_f & mask);

   always_comb begin
      b_res  = b_f;
      b_cout = 1'b0;
      case (b_op)
         OP_RRF: begin
            b_res  = {b_cin, b_f[WIDTH-1:1]};
            b_cout = b_f[0];
         end
         OP_RLF: begin
            b_res  = {b_f[WIDTH-2:0], b_cin};
            b_cout = b_f[WIDTH-1];
         end
         OP_BSF:  b_res = b_f | mask;
         OP_BCF:  b_res = b_f & ~mask;
         default: b_res = b_f;
      endcase
   end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int WIDTH         = 8,
   parameter bit SUB_VIA_ADDER = 1'b1,
   localparam int BIT_W        = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] w_in,
   input  logic [WIDTH-1:0] f_in,
   input  logic [WIDTH-1:0] lit_in,
   input  logic [BIT_W-1:0] bit_sel,
   input  logic [4:0]       op,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero_out,
   output logic             carry_we,
   output logic             zero_we,
   output logic             skip
);
   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu8_core: WIDTH must be even and at least 4");
      end
      if ((1 << BIT_W) != WIDTH) begin : g_bad_pow2
         $error("alu8_core: WIDTH must be a power of two");
      end
   endgenerate

   alu_op_e          op_e;
   alu_grp_e         grp;
   logic [WIDTH-1:0] arith_res, logic_res, bit_res;
   logic             arith_cout, rot_cout, test_bit;

   assign op_e = alu_op_e'(op);
   assign grp  = op_group(op_e);

   alu8_arith #(.WIDTH(WIDTH), .SUB_VIA_ADDER(SUB_VIA_ADDER)) u_arith (
      .a_w   (w_in),
      .a_f   (f_in),
      .a_op  (op_e),
      .a_res (arith_res),
      .a_cout(arith_cout)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .l_w  (w_in),
      .l_f  (f_in),
      .l_lit(lit_in),
      .l_op (op_e),
      .l_res(logic_res)
   );

   alu8_bitrot #(.WIDTH(WIDTH)) u_bitrot (
      .b_f   (f_in),
      .b_cin (carry_in),
      .b_sel (bit_sel),
      .b_op  (op_e),
      .b_res (bit_res),
      .b_cout(rot_cout),
      .b_tbit(test_bit)
   );

   always_comb begin
      case (grp)
         GRP_ARITH:  result = arith_res;
         GRP_LOGIC:  result = logic_res;
         GRP_BITROT: result = bit_res;
         default:    result = '0;
      endcase
   end

   assign zero_out = ~|result;

   always_comb begin
      carry_we  = 1'b0;
      carry_out = carry_in;
      case (op_e)
         OP_ADD, OP_SUB: begin
            carry_we  = 1'b1;
            carry_out = arith_cout;
         end
         OP_RRF, OP_RLF: begin
            carry_we  = 1'b1;
            carry_out = rot_cout;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (op_e)
         OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_AND, OP_IOR, OP_XOR,
         OP_COM, OP_MOVF, OP_CLR, OP_ANDLW, OP_IORLW, OP_XORLW:
            zero_we = 1'b1;
         default:
            zero_we = 1'b0;
      endcase
   end

   always_comb begin
      case (op_e)
         OP_INCSZ, OP_DECSZ: skip = ~|arith_res;
         OP_BTFSC:           skip = ~test_bit;
         OP_BTFSS:           skip = test_bit;
         default:            skip = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int BIT_W = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] w_in,
   input logic [WIDTH-1:0] f_in,
   input logic [WIDTH-1:0] lit_in,
   input logic [BIT_W-1:0] bit_sel,
   input logic [4:0]       op,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             carry_out,
   input logic             zero_out,
   input logic             carry_we,
   input logic             zero_we,
   input logic             skip
);
   alu_op_e o;
   assign o = alu_op_e'(op);

   always_comb begin
      // R10
      p_zero_match_r10: assert (zero_out == (result == '0))
         else $error("zero flag disagrees with result");
      // R14
      p_carry_hold_r14: assert (carry_we || carry_out == carry_in)
         else $error("carry changed without enable");
      // R7
      p_carry_src_r7: assert (!carry_we || o == OP_ADD || o == OP_SUB ||
                              o == OP_RRF || o == OP_RLF)
         else $error("carry enable on wrong op");
      // R13
      p_skip_ops_r13: assert (!skip || o == OP_INCSZ || o == OP_DECSZ ||
                              o == OP_BTFSC || o == OP_BTFSS)
         else $error("skip on non-skip op");
      // R4
      p_skip_noflag_r4: assert (!(o == OP_INCSZ || o == OP_DECSZ) ||
                                (!carry_we && !zero_we && skip == (result == '0)))
         else $error("counting skip op misbehaves");
      // R1
      p_add_sum_r1: assert (o != OP_ADD ||
                            {carry_out, result} == ({1'b0, f_in} + {1'b0, w_in}))
         else $error("add mismatch");
      // R8
      p_bit_set_r8: assert (o != OP_BSF || result[bit_sel] == 1'b1)
         else $error("bit set failed");
      // R9
      p_btest_keep_r9: assert (!(o == OP_BTFSC || o == OP_BTFSS) ||
                               (result == f_in && !carry_we && !zero_we))
         else $error("bit test altered state");
      // R12
      p_bad_op_r12: assert (op < 5'd24 ||
                            (result == '0 && !carry_we && !zero_we && !skip))
         else $error("unused op produced activity");
   end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu8_core.sv
`timescale 1ns / 1ps
module sim_alu8_core;
   import alu8_pkg::*;

   logic       clk = 1'b0;
   logic [7:0] w_in, f_in, lit_in;
   logic [2:0] bit_sel;
   logic [4:0] op;
   logic       carry_in;
   logic [7:0] result;
   logic       carry_out, zero_out, carry_we, zero_we, skip;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   alu8_core u0 (
      .w_in(w_in), .f_in(f_in), .lit_in(lit_in), .bit_sel(bit_sel),
      .op(op), .carry_in(carry_in), .result(result),
      .carry_out(carry_out), .zero_out(zero_out),
      .carry_we(carry_we), .zero_we(zero_we), .skip(skip)
   );

   task automatic apply(input logic [4:0] o, input logic [7:0] w, input logic [7:0] f,
                        input logic [7:0] l, input logic [2:0] b, input logic c);
      @(posedge clk);
      op = o; w_in = w; f_in = f; lit_in = l; bit_sel = b; carry_in = c;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   // flags packed as {carry_out, zero_out, carry_we, zero_we, skip}
   function automatic logic [4:0] fl();
      return {carry_out, zero_out, carry_we, zero_we, skip};
   endfunction

   task automatic t_idle;
      apply(OP_ADD, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R10 idle result", result, 8'h00);
      chk("R10 R13 idle flags", fl(), 5'b01110);
   endtask

   task automatic t_add;
      apply(OP_ADD, 8'hA0, 8'hA0, 8'h00, 3'd0, 1'b0);
      chk("R1 A0+A0", {carry_out, result}, 9'h140);
      apply(OP_ADD, 8'hA0, 8'h40, 8'h00, 3'd0, 1'b1);
      chk("R1 A0+40", {carry_out, result}, 9'h0E0);
      chk("R1 enables", {carry_we, zero_we}, 2'b11);
      apply(OP_ADD, 8'h80, 8'h80, 8'h00, 3'd0, 1'b0);
      chk("R1 R10 R13 80+80", fl(), 5'b11110);
   endtask

   task automatic t_sub;
      apply(OP_SUB, 8'h30, 8'hB0, 8'h00, 3'd0, 1'b0);
      chk("R2 B0-30", {carry_out, result}, 9'h180);
      apply(OP_SUB, 8'h30, 8'h20, 8'h00, 3'd0, 1'b1);
      chk("R2 20-30 borrow", {carry_out, result}, 9'h0F0);
      apply(OP_SUB, 8'h30, 8'h30, 8'h00, 3'd0, 1'b0);
      chk("R2 R10 30-30", fl(), 5'b11110);
   endtask

   task automatic t_incdec;
      apply(OP_INC, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b1);
      chk("R3 inc wrap", result, 8'h00);
      chk("R3 R14 inc flags", fl(), 5'b11010);
      apply(OP_DEC, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R3 dec wrap", result, 8'hFF);
      chk("R3 dec flags", fl(), 5'b00010);
   endtask

   task automatic t_skipcnt;
      apply(OP_INCSZ, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b0);
      chk("R4 incsz wrap", {result, fl()}, {8'h00, 5'b01001});
      apply(OP_DECSZ, 8'h00, 8'h05, 8'h00, 3'd0, 1'b0);
      chk("R4 decsz nonzero", {result, fl()}, {8'h04, 5'b00000});
      apply(OP_DECSZ, 8'h00, 8'h01, 8'h00, 3'd0, 1'b1);
      chk("R4 decsz to zero", {result, fl()}, {8'h00, 5'b11001});
   endtask

   task automatic t_logic;
      apply(OP_AND, 8'h73, 8'hFA, 8'h00, 3'd0, 1'b0);
      chk("R5 and", {result, carry_we, zero_we}, {8'h72, 2'b01});
      apply(OP_IOR, 8'h05, 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R5 ior", result, 8'h05);
      apply(OP_XOR, 8'hF0, 8'h72, 8'h00, 3'd0, 1'b0);
      chk("R5 xor", result, 8'h82);
      apply(OP_XORLW, 8'hFE, 8'h11, 8'hFE, 3'd0, 1'b1);
      chk("R5 xorlw", {result, fl()}, {8'h00, 5'b11010});
      apply(OP_ANDLW, 8'h3C, 8'h00, 8'h0F, 3'd0, 1'b0);
      chk("R5 andlw", result, 8'h0C);
      apply(OP_IORLW, 8'h30, 8'hFF, 8'h03, 3'd0, 1'b0);
      chk("R5 iorlw", result, 8'h33);
   endtask

   task automatic t_unary;
      apply(OP_COM, 8'h00, 8'h05, 8'h00, 3'd0, 1'b0);
      chk("R6 com", {result, zero_we}, {8'hFA, 1'b1});
      apply(OP_SWAP, 8'h00, 8'h82, 8'h00, 3'd0, 1'b0);
      chk("R6 swap", {result, carry_we, zero_we}, {8'h28, 2'b00});
      apply(OP_CLR, 8'h55, 8'h99, 8'h00, 3'd0, 1'b0);
      chk("R6 clr", {result, fl()}, {8'h00, 5'b01010});
      apply(OP_MOVF, 8'h44, 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R6 movf zero", {result, fl()}, {8'h00, 5'b01010});
   endtask

   task automatic t_rot;
      apply(OP_RRF, 8'h00, 8'hA0, 8'h00, 3'd0, 1'b1);
      chk("R7 rrf c=1", {carry_out, result}, 9'h0D0);
      apply(OP_RLF, 8'h00, 8'hA0, 8'h00, 3'd0, 1'b1);
      chk("R7 rlf c=1", {carry_out, result}, 9'h141);
      apply(OP_RRF, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0);
      chk("R7 rrf flags", {result, fl()}, {8'h00, 5'b11100});
   endtask

   task automatic t_bits;
      apply(OP_BSF, 8'h00, 8'h28, 8'h00, 3'd7, 1'b0);
      chk("R8 bsf7", {result, carry_we, zero_we}, {8'hA8, 2'b00});
      apply(OP_BCF, 8'h00, 8'h28, 8'h00, 3'd5, 1'b1);
      chk("R8 bcf5", {result, fl()}, {8'h08, 5'b10000});
   endtask

   task automatic t_btest;
      apply(OP_BTFSS, 8'h00, 8'h04, 8'h00, 3'd2, 1'b0);
      chk("R9 btfss set", {result, fl()}, {8'h04, 5'b00001});
      apply(OP_BTFSC, 8'h00, 8'h04, 8'h00, 3'd2, 1'b0);
      chk("R9 btfsc set", {result, fl()}, {8'h04, 5'b00000});
      apply(OP_BTFSC, 8'h00, 8'hFB, 8'h00, 3'd2, 1'b1);
      chk("R9 btfsc clear", {result, fl()}, {8'hFB, 5'b10001});
   endtask

   task automatic t_pass;
      apply(OP_MOVW, 8'h3C, 8'h00, 8'h00, 3'd0, 1'b0);
      chk("R11 movw", {result, carry_we, zero_we}, {8'h3C, 2'b00});
      apply(OP_MOVLW, 8'h00, 8'h00, 8'h5A, 3'd0, 1'b0);
      chk("R11 movlw", {result, carry_we, zero_we}, {8'h5A, 2'b00});
   endtask

   task automatic t_bad;
      apply(5'd31, 8'hFF, 8'hFF, 8'hFF, 3'd1, 1'b1);
      chk("R12 R14 unused op", {result, fl()}, {8'h00, 5'b11000});
      apply(5'd24, 8'h01, 8'h02, 8'h03, 3'd1, 1'b0);
      chk("R12 first unused", {result, fl()}, {8'h00, 5'b01000});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      op = 5'd0; w_in = '0; f_in = '0; lit_in = '0; bit_sel = '0; carry_in = 1'b0;
      t_idle;
      t_add;
      t_sub;
      t_incdec;
      t_skipcnt;
      t_logic;
      t_unary;
      t_rot;
      t_bits;
      t_btest;
      t_pass;
      t_bad;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule